// File: doc/BRIEF.md
# Hot-Swap Gate Sequencer

This block is the digital sequencer for the gate of an external pass transistor in a hot-swap supply. It takes clocked comparator flags and drives four mutually exclusive gate commands: pull down, float, constant-current charge and snap to full enhancement. It also drives a power-good flag and a one-cycle fault-start pulse. The comparators, charge pump, current source and retry policy sit outside the block. After a fault the sequencer holds the gate low until reset.

The block first runs a power-up ramp. Once the gate has reached full enhancement, a rise of the step monitor that comes before the short-circuit flag arms a step cycle. Within that cycle the gate is pulled down for a fixed interval, floated for a second fixed interval and then ramped again. While the step monitor stays high, over-current excursions restart this cycle and do not count as faults. Both intervals are given in microseconds and converted to clock counts from the clock frequency when the design is elaborated.

The states are named as follows. IDLE is gate off. PU_RAMP is the power-up charge. FULL is full enhancement. ARMED means a step has been seen. STEP_PD is the timed pulldown, STEP_FLOAT the timed float and STEP_RAMP the recharge. STEP_HOLD holds the gate at 90 %. FLT_START lasts one cycle and starts fault handling, and FLT_HOLD holds the gate off.

The transitions are:
- go: IDLE to PU_RAMP.
- pu_ok: PU_RAMP to FULL.
- pu_fail: PU_RAMP to FLT_START.
- arm: FULL to ARMED.
- short: FULL to FLT_START.
- disarm: ARMED to FULL.
- trip: ARMED to STEP_PD.
- pd_done: STEP_PD to STEP_FLOAT.
- fl_done: STEP_FLOAT to STEP_RAMP.
- restart: STEP_RAMP or STEP_HOLD to STEP_PD.
- settle: STEP_RAMP or STEP_HOLD to FULL.
- park: STEP_RAMP to STEP_HOLD.
- step_fault: STEP_RAMP or STEP_HOLD to FLT_START.
- latch: FLT_START to FLT_HOLD.

Top module: `hsg_gate_seq`

## Requirements
- R1: A low rst_n at a rising edge gives state IDLE. In IDLE gate_pd_o is 1 and every other output is 0.
- R2: Each input passes through two register stages. A value first present at rising edge k steers the state at edge k+2, so the outputs change after the third edge that sees it.
- R3: In IDLE, pu_go_i starts PU_RAMP, which drives gate_chg_o only. In PU_RAMP, out_lo_i leads to FULL, which drives gate_snap_o and pgood_o. Otherwise, gate90_i leads to a fault.
- R4: In FULL, out_sc_i gives a fault. Otherwise step_hi_i gives ARMED, whose outputs match FULL. In ARMED, a fall of step_hi_i with out_sc_i low returns to FULL.
- R5: out_sc_i in ARMED enters STEP_PD. This state drives gate_pd_o and pgood_o for exactly CLK_MHZ*PD_US cycles.
- R6: STEP_PD is followed by STEP_FLOAT, which drives gate_float_o and pgood_o for exactly CLK_MHZ*FL_US cycles. STEP_FLOAT is followed by STEP_RAMP, which drives gate_chg_o and pgood_o.
- R7: In STEP_RAMP, with out_sc_i low, out_lo_i leads to FULL.
- R8: In STEP_RAMP, gate90_i with out_lo_i and out_sc_i low and step_hi_i high leads to STEP_HOLD. In STEP_HOLD only pgood_o is 1.
- R9: In STEP_HOLD with out_sc_i low, out_lo_i leads to FULL. If out_lo_i is low instead, a low step_hi_i leads to a fault.
- R10: In STEP_RAMP, gate90_i with out_lo_i, out_sc_i and step_hi_i all low leads to a fault.
- R11: In STEP_RAMP or STEP_HOLD, out_sc_i restarts STEP_PD when step_hi_i is high and gives a fault when step_hi_i is low. This check takes priority over all others in those states.
- R12: pgood_o is 1 in every step state. A fault passes through FLT_START for one cycle, with gate_pd_o and fault_start_o high and pgood_o low. It then goes to FLT_HOLD, which has only gate_pd_o high and ignores all inputs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| step_hi_i | input | 1 | step monitor above its threshold |
| out_sc_i | input | 1 | output above the short-circuit threshold |
| out_lo_i | input | 1 | output below 72 % of the breaker level |
| gate90_i | input | 1 | gate at 90 % of full enhancement |
| pu_go_i | input | 1 | start the power-up gate cycle |
| gate_pd_o | output | 1 | pull the gate to the negative rail |
| gate_float_o | output | 1 | leave the gate undriven |
| gate_chg_o | output | 1 | enable constant-current gate charge |
| gate_snap_o | output | 1 | snap the gate to full enhancement |
| pgood_o | output | 1 | power good |
| fault_start_o | output | 1 | one-cycle start of fault management |

## Verification
The bench builds the block with CLK_MHZ=1 and the default 350/650 µs intervals. With these values the pulldown window is 350 cycles and the float window is 650 cycles. A complete step cycle therefore fits in about a thousand cycles, so restart, hold and fault paths can all be run back to back. These values still leave counts wide enough that an off-by-one timer length shows up at the window edges.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_RAMP,
        ST_FULL,
        ST_ARMED,
        ST_STEP_PD,
        ST_STEP_FLOAT,
        ST_STEP_RAMP,
        ST_STEP_HOLD,
        ST_FLT_START,
        ST_FLT_HOLD
    } gate_state_e;

    typedef struct packed {
        logic step_hi;
        logic out_sc;
        logic out_lo;
        logic gate90;
        logic pu_go;
    } cmp_flags_t;

    localparam int NFLAGS = $bits(cmp_flags_t);

endpackage

// File: rtl/hsg_sync.sv
module hsg_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[k] <= '0;
                else        pipe[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[k] <= '0;
                else        pipe[k] <= pipe[k-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsg_timer.sv
module hsg_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/hsg_gate_seq.sv
module hsg_gate_seq
    import hsg_pkg::*;
#(
    parameter int CLK_MHZ = 50,
    parameter int PD_US   = 350,
    parameter int FL_US   = 650
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_hi_i,
    input  logic out_sc_i,
    input  logic out_lo_i,
    input  logic gate90_i,
    input  logic pu_go_i,
    output logic gate_pd_o,
    output logic gate_float_o,
    output logic gate_chg_o,
    output logic gate_snap_o,
    output logic pgood_o,
    output logic fault_start_o
);
    localparam int PD_CYC = CLK_MHZ * PD_US;
    localparam int FL_CYC = CLK_MHZ * FL_US;
    localparam int MAXC   = (PD_CYC > FL_CYC) ? PD_CYC : FL_CYC;
    localparam int TW     = $clog2(MAXC + 1);

    cmp_flags_t  raw, flg;
    gate_state_e state, nxt;
    logic        tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;

    assign raw = '{step_hi: step_hi_i, out_sc: out_sc_i, out_lo: out_lo_i,
                   gate90: gate90_i, pu_go: pu_go_i};

    hsg_sync #(.W(NFLAGS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(flg)
    );

    hsg_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
    );

    // next-state and timer load
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = TW'(PD_CYC - 1);
        unique case (state)
            ST_IDLE:    if (flg.pu_go) nxt = ST_PU_RAMP;
            ST_PU_RAMP: begin
                if (flg.out_lo)      nxt = ST_FULL;
                else if (flg.gate90) nxt = ST_FLT_START;
            end
            ST_FULL: begin
                if (flg.out_sc)       nxt = ST_FLT_START;
                else if (flg.step_hi) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (flg.out_sc) begin
                    nxt      = ST_STEP_PD;
                    tmr_load = 1'b1;
                end else if (!flg.step_hi) begin
                    nxt = ST_FULL;
                end
            end
            ST_STEP_PD: begin
                if (tmr_done) begin
                    nxt      = ST_STEP_FLOAT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(FL_CYC - 1);
                end
            end
            ST_STEP_FLOAT: if (tmr_done) nxt = ST_STEP_RAMP;
            ST_STEP_RAMP, ST_STEP_HOLD: begin
                if (flg.out_sc) begin
                    if (flg.step_hi) begin
                        nxt      = ST_STEP_PD;
                        tmr_load = 1'b1;
                    end else begin
                        nxt = ST_FLT_START;
                    end
                end else if (flg.out_lo) begin
                    nxt = ST_FULL;
                end else if (state == ST_STEP_RAMP) begin
                    if (flg.gate90) nxt = flg.step_hi ? ST_STEP_HOLD : ST_FLT_START;
                end else if (!flg.step_hi) begin
                    nxt = ST_FLT_START;
                end
            end
            ST_FLT_START: nxt = ST_FLT_HOLD;
            ST_FLT_HOLD:  nxt = ST_FLT_HOLD;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Moore outputs
    always_comb begin
        gate_pd_o     = 1'b0;
        gate_float_o  = 1'b0;
        gate_chg_o    = 1'b0;
        gate_snap_o   = 1'b0;
        pgood_o       = 1'b0;
        fault_start_o = 1'b0;
        unique case (state)
            ST_IDLE:       gate_pd_o = 1'b1;
            ST_PU_RAMP:    gate_chg_o = 1'b1;
            ST_FULL,
            ST_ARMED:      begin gate_snap_o = 1'b1; pgood_o = 1'b1; end
            ST_STEP_PD:    begin gate_pd_o = 1'b1; pgood_o = 1'b1; end
            ST_STEP_FLOAT: begin gate_float_o = 1'b1; pgood_o = 1'b1; end
            ST_STEP_RAMP:  begin gate_chg_o = 1'b1; pgood_o = 1'b1; end
            ST_STEP_HOLD:  pgood_o = 1'b1;
            ST_FLT_START:  begin gate_pd_o = 1'b1; fault_start_o = 1'b1; end
            ST_FLT_HOLD:   gate_pd_o = 1'b1;
            default:       gate_pd_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/hsg_gate_seq_chk.sv
module hsg_gate_seq_chk #(
    parameter int CLK_MHZ = 50,
    parameter int PD_US   = 350,
    parameter int FL_US   = 650
) (
    input logic clk,
    input logic rst_n,
    input logic gate_pd_o,
    input logic gate_float_o,
    input logic gate_chg_o,
    input logic gate_snap_o,
    input logic pgood_o,
    input logic fault_start_o
);
    localparam int PD_CYC = CLK_MHZ * PD_US;
    localparam int FL_CYC = CLK_MHZ * FL_US;

    int pd_run, fl_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_run <= 0;
            fl_run <= 0;
        end else begin
            pd_run <= (gate_pd_o && pgood_o) ? pd_run + 1 : 0;
            fl_run <= gate_float_o ? fl_run + 1 : 0;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (gate_pd_o && !pgood_o && !fault_start_o));

    p_drive_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate_pd_o, gate_float_o, gate_chg_o, gate_snap_o}));

    p_snap_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_snap_o |-> pgood_o);

    p_pd_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_float_o) && pgood_o) |-> (pd_run == PD_CYC));

    p_fl_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_chg_o) && pgood_o) |-> (fl_run == FL_CYC));

    p_fault_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_start_o |=> (!fault_start_o && gate_pd_o && !pgood_o));

    p_pg_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgood_o) |-> fault_start_o);
endmodule

bind hsg_gate_seq hsg_gate_seq_chk #(
    .CLK_MHZ(CLK_MHZ), .PD_US(PD_US), .FL_US(FL_US)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .gate_pd_o(gate_pd_o), .gate_float_o(gate_float_o),
    .gate_chg_o(gate_chg_o), .gate_snap_o(gate_snap_o),
    .pgood_o(pgood_o), .fault_start_o(fault_start_o)
);

// File: tb/tb_hsg_gate_seq.sv
module tb_hsg_gate_seq;
    localparam int CLK_MHZ = 1;
    localparam int PD_US   = 350;
    localparam int FL_US   = 650;
    localparam int PDC     = CLK_MHZ * PD_US;
    localparam int FLC     = CLK_MHZ * FL_US;

    // model phases
    localparam int M_OFF = 0, M_PU = 1, M_FULL = 2, M_ARM = 3, M_PD = 4, M_FL = 5,
                   M_RAMP = 6, M_HOLD = 7, M_FS = 8, M_FH = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_hi = 0, out_sc = 0, out_lo = 0, gate90 = 0, pu_go = 0;
    logic pd, fl, chg, snap, pg, fs;
    logic [5:0] act;

    int checks = 0, errors = 0, cyc = 0;
    bit run_cmp = 0, done = 0;
    int m_ph = M_OFF, m_el = 0;
    logic [4:0] q[$];
    logic [4:0] v;

    always #10 clk = ~clk;

    hsg_gate_seq #(.CLK_MHZ(CLK_MHZ), .PD_US(PD_US), .FL_US(FL_US)) dut (
        .clk(clk), .rst_n(rst_n), .step_hi_i(step_hi), .out_sc_i(out_sc),
        .out_lo_i(out_lo), .gate90_i(gate90), .pu_go_i(pu_go),
        .gate_pd_o(pd), .gate_float_o(fl), .gate_chg_o(chg), .gate_snap_o(snap),
        .pgood_o(pg), .fault_start_o(fs)
    );

    assign act = {pd, fl, chg, snap, pg, fs};

    function automatic logic [5:0] exp_of(int p);
        case (p)
            M_OFF:          return 6'b100000;
            M_PU:           return 6'b001000;
            M_FULL, M_ARM:  return 6'b000110;
            M_PD:           return 6'b100010;
            M_FL:           return 6'b010010;
            M_RAMP:         return 6'b001010;
            M_HOLD:         return 6'b000010;
            M_FS:           return 6'b100001;
            default:        return 6'b100000;
        endcase
    endfunction

    function automatic string tag_of(int p);
        case (p)
            M_OFF:          return "R1";
            M_PU:           return "R3";
            M_FULL, M_ARM:  return "R4";
            M_PD:           return "R5";
            M_FL:           return "R6";
            M_RAMP:         return "R7";
            M_HOLD:         return "R8";
            default:        return "R12";
        endcase
    endfunction

    // behavioural reference: two-cycle input delay, then phase rules
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = M_OFF; m_el = 0;
            q.delete(); q.push_back(5'b0); q.push_back(5'b0);
        end else begin
            v = q[0]; // {step, sc, lo, g90, go}
            case (m_ph)
                M_OFF:  if (v[0]) m_ph = M_PU;
                M_PU:   if (v[2]) m_ph = M_FULL; else if (v[1]) m_ph = M_FS;
                M_FULL: if (v[3]) m_ph = M_FS; else if (v[4]) m_ph = M_ARM;
                M_ARM:  if (v[3]) begin m_ph = M_PD; m_el = 0; end
                        else if (!v[4]) m_ph = M_FULL;
                M_PD:   begin m_el++; if (m_el == PDC) begin m_ph = M_FL; m_el = 0; end end
                M_FL:   begin m_el++; if (m_el == FLC) begin m_ph = M_RAMP; m_el = 0; end end
                M_RAMP, M_HOLD: begin
                    if (v[3] && v[4]) begin m_ph = M_PD; m_el = 0; end
                    else if (v[3]) m_ph = M_FS;
                    else if (v[2]) m_ph = M_FULL;
                    else if (m_ph == M_RAMP && v[1]) m_ph = v[4] ? M_HOLD : M_FS;
                    else if (m_ph == M_HOLD && !v[4]) m_ph = M_FS;
                end
                M_FS:   m_ph = M_FH;
                default: m_ph = m_ph;
            endcase
            void'(q.pop_front());
            q.push_back({step_hi, out_sc, out_lo, gate90, pu_go});
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (run_cmp && !done) begin
            checks++;
            if (act !== exp_of(m_ph)) begin
                errors++;
                $display("FAIL %s model cycle: actual=%b expected=%b", tag_of(m_ph), act, exp_of(m_ph));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            finish_run();
        end
    end

    task automatic chk(string tag, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic clr();
        step_hi = 0; out_sc = 0; out_lo = 0; gate90 = 0; pu_go = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_ph(int p);
        for (int i = 0; i < 5000 && m_ph != p; i++) @(negedge clk);
    endtask

    task automatic power_up();
        pu_go = 1; wait_ph(M_PU); pu_go = 0;
        out_lo = 1; wait_ph(M_FULL); out_lo = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic to_ramp(bit keep_step);
        step_hi = 1; repeat (4) @(negedge clk);
        out_sc = 1; wait_ph(M_PD); out_sc = 0;
        if (!keep_step) step_hi = 0;
        wait_ph(M_RAMP); repeat (3) @(negedge clk);
    endtask

    initial begin
        do_reset();
        run_cmp = 1;
        chk("R1 reset outputs", 6'b100000);

        // R2 latency and R3 power-up success
        pu_go = 1;
        @(negedge clk); chk("R2 after 1 edge", 6'b100000);
        @(negedge clk); chk("R2 after 2 edges", 6'b100000);
        @(negedge clk); chk("R2 after 3 edges", 6'b001000);
        pu_go = 0; out_lo = 1;
        repeat (3) @(negedge clk); chk("R3 power-up full", 6'b000110);
        out_lo = 0;

        // R4 arm and disarm, then R5/R6 exact windows, R7 settle
        step_hi = 1; repeat (4) @(negedge clk); chk("R4 armed unchanged", 6'b000110);
        step_hi = 0; repeat (4) @(negedge clk); chk("R4 disarm", 6'b000110);
        step_hi = 1; repeat (4) @(negedge clk);
        out_sc = 1; repeat (3) @(negedge clk); chk("R5 pulldown start", 6'b100010);
        out_sc = 0;
        repeat (PDC - 1) @(negedge clk); chk("R5 pulldown last", 6'b100010);
        @(negedge clk); chk("R6 float start", 6'b010010);
        repeat (FLC - 1) @(negedge clk); chk("R6 float last", 6'b010010);
        @(negedge clk); chk("R6 charge start", 6'b001010);
        out_lo = 1; repeat (3) @(negedge clk); chk("R7 settle full", 6'b000110);
        clr(); repeat (3) @(negedge clk);

        // R8 hold then R9 settle
        do_reset(); power_up(); to_ramp(1);
        gate90 = 1; repeat (3) @(negedge clk); chk("R8 hold", 6'b000010);
        repeat (10) @(negedge clk); chk("R8 hold stays", 6'b000010);
        out_lo = 1; repeat (3) @(negedge clk); chk("R9 hold to full", 6'b000110);
        clr(); repeat (3) @(negedge clk);

        // R9 hold then step falls -> fault, R12 latch
        do_reset(); power_up(); to_ramp(1);
        gate90 = 1; repeat (3) @(negedge clk);
        step_hi = 0; repeat (3) @(negedge clk); chk("R9 hold step fall fault", 6'b100001);
        @(negedge clk); chk("R12 fault hold", 6'b100000);
        out_lo = 1; pu_go = 1; repeat (20) @(negedge clk); chk("R12 fault ignores inputs", 6'b100000);
        clr();

        // R10 gate90 with step low
        do_reset(); power_up(); to_ramp(0);
        gate90 = 1; repeat (3) @(negedge clk); chk("R10 ramp fault", 6'b100001);
        clr();

        // R11 restart with step high, then settle
        do_reset(); power_up(); to_ramp(1);
        out_sc = 1; repeat (3) @(negedge clk); chk("R11 restart pulldown", 6'b100010);
        out_sc = 0; wait_ph(M_RAMP); repeat (2) @(negedge clk);
        chk("R11 second ramp", 6'b001010);
        out_lo = 1; repeat (3) @(negedge clk); chk("R7 settle after restart", 6'b000110);
        clr(); repeat (3) @(negedge clk);

        // R11 short with step low during ramp
        do_reset(); power_up(); to_ramp(0);
        out_sc = 1; repeat (3) @(negedge clk); chk("R11 short step low", 6'b100001);
        clr();

        // R4 short in full without step
        do_reset(); power_up();
        out_sc = 1; repeat (3) @(negedge clk); chk("R4 short in full", 6'b100001);
        clr();

        // R3 power-up fault
        do_reset();
        pu_go = 1; wait_ph(M_PU); pu_go = 0;
        gate90 = 1; repeat (3) @(negedge clk); chk("R3 power-up fault", 6'b100001);
        clr(); repeat (3) @(negedge clk);

        finish_run();
    end
endmodule